// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block converts a single PWM command into two mutually exclusive gate-enable signals for the upper and lower switches of a half bridge. Every hand-over between the two switches follows the same steps. The conducting gate stays on for a programmable propagation interval and is then dropped. The block waits until the feedback flag of that gate reports that it has discharged. Only then does a programmable dead-time count run, and the opposite gate is enabled when the count expires. The PWM command and both feedback flags are resynchronised through two-flop stages before the sequencer uses them.

Two supply-health monitors qualify the outputs. Each one takes a pair of digitised comparator flags: the supply is above its upper (turn-on) threshold, and the supply is above its lower (turn-off) threshold. From these the monitor keeps a lockout state with hysteresis. A lockout of the main rail silences both gates. A lockout of the bootstrap rail silences only the upper gate, and the lower gate goes on following the command. When a lockout clears, the gates come back only through the normal wait-then-dead-time sequence. Clocking is single-domain, and reset is synchronous and active high.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: With `pwm_cmd`=1 in steady state, `hs_gate`=1 and `ls_gate`=0. With `pwm_cmd`=0 in steady state, `hs_gate`=0 and `ls_gate`=1.
- R2: After `pwm_cmd` changes, the conducting gate drops on clock edge 3+P counted from the change. P is `prop_cyc`, and the 3 is two synchroniser stages plus one sequencer register. With P=0 there is no hold interval.
- R3: The incoming gate is never enabled while the outgoing gate's synchronised feedback is still high. The dead-time count starts only in a cycle where that feedback is seen low.
- R4: Once the outgoing feedback is seen low, the incoming gate rises exactly Deff cycles later, with Deff = max(`dead_cyc`,1). With feedback that falls L cycles after its gate, the incoming gate therefore rises on edge 6+P+L+Deff after the command change.
- R5: A `dead_cyc` of 0 gives the same timing as a `dead_cyc` of 1.
- R6: `hs_gate` and `ls_gate` are never both high in the same cycle.
- R7: If the command reverses while the sequencer is waiting for feedback or counting dead time, the pending gate is never enabled. The sequence restarts toward the new side: it waits for the feedback, then counts the full dead time.
- R8: During reset and while the main rail is locked out, both gates are low. A main lockout forces both gates low one cycle after the flags drop. Reset leaves both rails locked out.
- R9: A bootstrap lockout drives only `hs_gate` low, one cycle after its flags drop. While it lasts, `ls_gate` keeps following `pwm_cmd` with the normal timing.
- R10: Each rail enters lockout only when both of its flags are 0. It leaves lockout only when its above-on flag is 1. With above-off=1 and above-on=0 it keeps its previous state.
- R11: After a lockout clears, the commanded gate returns only through the feedback wait and the full dead time. After a main clear it rises on edge 3+Deff. After a bootstrap clear it rises on edge 2+Deff.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | PWM command: 1 selects the upper switch, 0 selects the lower |
| hs_fb | input | 1 | Upper gate feedback: 1 while the gate voltage is above its threshold |
| ls_fb | input | 1 | Lower gate feedback: 1 while the gate voltage is above its threshold |
| vmain_above_on | input | 1 | Main rail is above its upper (turn-on) threshold |
| vmain_above_off | input | 1 | Main rail is above its lower (turn-off) threshold |
| vboot_above_on | input | 1 | Bootstrap rail is above its upper threshold |
| vboot_above_off | input | 1 | Bootstrap rail is above its lower threshold |
| prop_cyc | input | PROP_W | Propagation hold, in clock cycles |
| dead_cyc | input | DEAD_W | Dead time, in clock cycles (0 is taken as 1) |
| hs_gate | output | 1 | Upper gate enable |
| ls_gate | output | 1 | Lower gate enable |

## Verification
Several properties are checked on every cycle of every test. The two gates never overlap. A gate rises only when it leaves the dead-time state. The dead-time state is entered only after the outgoing feedback was low. A main lockout always returns the sequencer to idle. The band-hold and trip rules of each supply monitor are checked the same way. Exact cycle counts need the bench's directed scenarios: hold time, feedback lag, the dead time of 0 against 1, the retargeting on a mid-sequence reversal, the lower gate running on under a bootstrap lockout, and the re-entry timing after each kind of lockout.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // both gates off, waiting for main rail
    ST_ON   = 3'd1,  // tgt side conducting
    ST_PROP = 3'd2,  // tgt side still conducting, hold interval running
    ST_WAIT = 3'd3,  // both off, waiting for outgoing feedback to fall
    ST_DEAD = 3'd4   // both off, dead-time interval running
  } hb_state_e;

  // Effective dead time: a zero setting still gives one cycle.
  function automatic logic [31:0] dead_span(input logic [31:0] setting);
    return (setting == 32'd0) ? 32'd1 : setting;
  endfunction

  // True in the last cycle of an interval of 'span' cycles.
  function automatic logic span_done(input logic [31:0] elapsed,
                                     input logic [31:0] span);
    return (elapsed + 32'd1) >= span;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/hb_uv_hyst.sv
module hb_uv_hyst (
  input  logic clk,
  input  logic rst,
  input  logic above_on,
  input  logic above_off,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)             locked <= 1'b1;
    else if (above_on)   locked <= 1'b0;
    else if (!above_off) locked <= 1'b1;
  end

  AST_UV_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (above_off && !above_on) |=> $stable(locked)); // R10
  AST_UV_TRIPS: assert property (@(posedge clk) disable iff (rst)
    (!above_off && !above_on) |=> locked); // R10
endmodule

// File: rtl/hb_span_timer.sv
module hb_span_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] elapsed
);
  always_ff @(posedge clk) begin
    if (rst || clr)         elapsed <= '0;
    else if (elapsed != '1) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int PROP_W = 4,
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_cmd,
  input  logic              hs_fb,
  input  logic              ls_fb,
  input  logic              vmain_above_on,
  input  logic              vmain_above_off,
  input  logic              vboot_above_on,
  input  logic              vboot_above_off,
  input  logic [PROP_W-1:0] prop_cyc,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic              hs_gate,
  output logic              ls_gate
);
  localparam int CNT_W     = (PROP_W > DEAD_W) ? PROP_W : DEAD_W;
  localparam int N_RAIL    = 2;
  localparam int RAIL_MAIN = 0;
  localparam int RAIL_BOOT = 1;

  // Resynchronised command and feedback
  logic [2:0] sync_q;
  logic       pwm_s, hfb_s, lfb_s;

  hb_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pwm_cmd, hs_fb, ls_fb}),
    .q   (sync_q)
  );
  assign {pwm_s, hfb_s, lfb_s} = sync_q;

  // Supply lockout monitors
  logic [N_RAIL-1:0] rail_on, rail_off, rail_lock;
  assign rail_on  = {vboot_above_on,  vmain_above_on};
  assign rail_off = {vboot_above_off, vmain_above_off};

  for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
    hb_uv_hyst u_uv (
      .clk       (clk),
      .rst       (rst),
      .above_on  (rail_on[g]),
      .above_off (rail_off[g]),
      .locked    (rail_lock[g])
    );
  end

  logic main_lock, boot_lock;
  assign main_lock = rail_lock[RAIL_MAIN];
  assign boot_lock = rail_lock[RAIL_BOOT];

  // Sequencer state
  hb_state_e state_q, nxt_state;
  logic      tgt_q, nxt_tgt;   // 1 = upper side
  logic [CNT_W-1:0] elapsed;
  logic [31:0]      span_lim;
  logic             tmr_done, tmr_clr;

  // Named internal events
  logic off_fb_s;     // synchronised feedback of the gate opposite tgt
  logic hs_blocked;   // target is the upper side but bootstrap is locked
  logic cmd_flip;     // command disagrees with the current target
  logic dead_expire;  // dead time finished, gate about to turn on
  logic drive_on;

  assign off_fb_s   = tgt_q ? lfb_s : hfb_s;
  assign hs_blocked = tgt_q & boot_lock;
  assign cmd_flip   = (pwm_s != tgt_q);
  assign span_lim   = (state_q == ST_PROP) ? 32'(prop_cyc)
                                           : dead_span(32'(dead_cyc));
  assign tmr_done   = span_done(32'(elapsed), span_lim);

  hb_span_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .elapsed (elapsed)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_tgt   = tgt_q;
    case (state_q)
      ST_IDLE: begin
        nxt_state = ST_WAIT;
        nxt_tgt   = pwm_s;
      end
      ST_ON: begin
        if (hs_blocked) begin
          nxt_state = ST_WAIT;
          nxt_tgt   = pwm_s;
        end else if (cmd_flip) begin
          if (prop_cyc == '0) begin
            nxt_state = ST_WAIT;
            nxt_tgt   = pwm_s;
          end else begin
            nxt_state = ST_PROP;
          end
        end
      end
      ST_PROP: begin
        if (hs_blocked) begin
          nxt_state = ST_WAIT;
          nxt_tgt   = pwm_s;
        end else if (!cmd_flip) begin
          nxt_state = ST_ON;
        end else if (tmr_done) begin
          nxt_state = ST_WAIT;
          nxt_tgt   = pwm_s;
        end
      end
      ST_WAIT: begin
        if (cmd_flip)                      nxt_tgt   = pwm_s;
        else if (!off_fb_s && !hs_blocked) nxt_state = ST_DEAD;
      end
      ST_DEAD: begin
        if (cmd_flip) begin
          nxt_state = ST_WAIT;
          nxt_tgt   = pwm_s;
        end else if (hs_blocked) begin
          nxt_state = ST_WAIT;
        end else if (tmr_done) begin
          nxt_state = ST_ON;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
    if (main_lock) begin
      nxt_state = ST_IDLE;
      nxt_tgt   = tgt_q;
    end
  end

  assign tmr_clr     = (nxt_state != state_q);
  assign dead_expire = (state_q == ST_DEAD) && (nxt_state == ST_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= nxt_state;
      tgt_q   <= nxt_tgt;
    end
  end

  assign drive_on = (state_q == ST_ON) || (state_q == ST_PROP);
  assign hs_gate  = drive_on &  tgt_q & ~main_lock & ~boot_lock;
  assign ls_gate  = drive_on & ~tgt_q & ~main_lock;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate)); // R6
  AST_HS_ONLY_AFTER_DEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> $past(dead_expire)); // R4
  AST_LS_ONLY_AFTER_DEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> $past(dead_expire)); // R4
  AST_DEAD_NEEDS_QUIET_FB: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEAD && $past(state_q) == ST_WAIT) |-> !$past(off_fb_s)); // R3
  AST_MAIN_LOCK_IDLES: assert property (@(posedge clk) disable iff (rst)
    main_lock |=> (state_q == ST_IDLE)); // R8
endmodule

// File: tb/tb_hb_deadtime_ctrl.sv
module tb_hb_deadtime_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_cmd = 1'b0;
  logic       hs_fb = 1'b0, ls_fb = 1'b0;
  logic       vmain_above_on = 1'b0, vmain_above_off = 1'b0;
  logic       vboot_above_on = 1'b0, vboot_above_off = 1'b0;
  logic [3:0] prop_cyc = 4'd2;
  logic [7:0] dead_cyc = 8'd4;
  logic       hs_gate, ls_gate;

  int checks = 0;
  int failures = 0;
  int fb_lag = 0;
  logic stuck_h = 1'b0, stuck_l = 1'b0;
  logic [3:0] hist_h = '0, hist_l = '0;

  always #5 clk = ~clk;

  hb_deadtime_ctrl dut (
    .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .hs_fb(hs_fb), .ls_fb(ls_fb),
    .vmain_above_on(vmain_above_on), .vmain_above_off(vmain_above_off),
    .vboot_above_on(vboot_above_on), .vboot_above_off(vboot_above_off),
    .prop_cyc(prop_cyc), .dead_cyc(dead_cyc),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // Gate feedback model: follows each gate with fb_lag extra cycles.
  always @(negedge clk) begin
    hist_h = {hist_h[2:0], hs_gate};
    hist_l = {hist_l[2:0], ls_gate};
    hs_fb  = hist_h[fb_lag] | stuck_h;
    ls_fb  = hist_l[fb_lag] | stuck_l;
  end

  task automatic check_int(input string req, input string what,
                           input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Drive a new command, return the edge counts of the outgoing gate
  // falling and the incoming gate rising, and whether they overlapped.
  task automatic step_pwm(input logic v, output int t_off, output int t_on,
                          output int overlap);
    logic og, ig;
    t_off = -1; t_on = -1; overlap = 0;
    pwm_cmd = v;
    for (int n = 1; n <= 60; n++) begin
      @(posedge clk);
      @(negedge clk);
      og = v ? ls_gate : hs_gate;
      ig = v ? hs_gate : ls_gate;
      if (hs_gate && ls_gate) overlap++;
      if (t_off < 0 && !og) t_off = n;
      if (t_on < 0 && ig)   t_on = n;
    end
  endtask

  task automatic t_reset_and_start();
    tick(3);
    check_int("R8", "hs during lockout after reset", int'(hs_gate), 0);
    check_int("R8", "ls during lockout after reset", int'(ls_gate), 0);
    vmain_above_on = 1; vmain_above_off = 1;
    vboot_above_on = 1; vboot_above_off = 1;
    begin
      int t = -1;
      for (int n = 1; n <= 30; n++) begin
        @(posedge clk); @(negedge clk);
        if (t < 0 && ls_gate) t = n;
      end
      check_int("R11", "ls rise after main clear", t, 3 + 4);
    end
    check_int("R1", "hs low with pwm 0", int'(hs_gate), 0);
    check_int("R1", "ls high with pwm 0", int'(ls_gate), 1);
  endtask

  task automatic t_switch(input int p, input int d, input int lag, input string tag);
    int t_off, t_on, ov, deff;
    prop_cyc = 4'(p); dead_cyc = 8'(d); fb_lag = lag;
    deff = (d == 0) ? 1 : d;
    tick(4);
    step_pwm(1'b1, t_off, t_on, ov);
    check_int("R2", {tag, " ls fall on rise"}, t_off, 3 + p);
    check_int((d == 0) ? "R5" : "R4", {tag, " hs rise"}, t_on, 6 + p + lag + deff);
    check_int("R6", {tag, " overlap on rise"}, ov, 0);
    check_int("R1", {tag, " steady hs"}, int'(hs_gate), 1);
    step_pwm(1'b0, t_off, t_on, ov);
    check_int("R2", {tag, " hs fall on fall"}, t_off, 3 + p);
    check_int((d == 0) ? "R5" : "R4", {tag, " ls rise"}, t_on, 6 + p + lag + deff);
    check_int("R6", {tag, " overlap on fall"}, ov, 0);
    check_int("R1", {tag, " steady ls"}, int'(ls_gate), 1);
    fb_lag = 0;
  endtask

  task automatic t_stuck_feedback();
    int hs_seen = 0, t = -1;
    prop_cyc = 4'd2; dead_cyc = 8'd4;
    stuck_l = 1'b1;
    tick(2);
    pwm_cmd = 1'b1;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate) hs_seen++;
    end
    check_int("R3", "hs held while ls feedback high", hs_seen, 0);
    stuck_l = 1'b0;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); @(negedge clk);
      if (t < 0 && hs_gate) t = n;
    end
    check_int("R3", "hs rise after feedback release", t, 3 + 4);
    pwm_cmd = 1'b0;
    tick(30);
  endtask

  task automatic t_abort();
    int hs_seen = 0, t = -1;
    prop_cyc = 4'd1; dead_cyc = 8'd20;
    tick(4);
    pwm_cmd = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate) hs_seen++;
    end
    check_int("R7", "ls off before reversal", int'(ls_gate), 0);
    pwm_cmd = 1'b0;
    for (int n = 1; n <= 60; n++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate) hs_seen++;
      if (t < 0 && ls_gate) t = n;
    end
    check_int("R7", "hs never enabled after abort", hs_seen, 0);
    check_int("R7", "ls return after full dead time", t, 4 + 20);
    prop_cyc = 4'd2; dead_cyc = 8'd4;
    tick(4);
  endtask

  task automatic t_main_lock();
    int t = -1, ls_seen = 0, bad = 0;
    pwm_cmd = 1'b1;
    tick(30);
    check_int("R1", "hs on before main lock", int'(hs_gate), 1);
    vmain_above_off = 0; vmain_above_on = 0;
    tick(1);
    check_int("R8", "hs one cycle after main trip", int'(hs_gate), 0);
    check_int("R8", "ls one cycle after main trip", int'(ls_gate), 0);
    vmain_above_off = 1;  // inside the band: lockout must persist
    for (int n = 1; n <= 10; n++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate || ls_gate) bad++;
    end
    check_int("R10", "band holds lockout", bad, 0);
    vmain_above_on = 1;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); @(negedge clk);
      if (ls_gate) ls_seen++;
      if (t < 0 && hs_gate) t = n;
    end
    check_int("R11", "hs rise after main clear", t, 3 + 4);
    check_int("R11", "ls stays off on re-entry", ls_seen, 0);
    bad = 0;
    vmain_above_on = 0;  // falling into the band: no lockout
    for (int n = 1; n <= 10; n++) begin
      @(posedge clk); @(negedge clk);
      if (!hs_gate) bad++;
    end
    check_int("R10", "band does not trip", bad, 0);
    vmain_above_on = 1;
  endtask

  task automatic t_boot_lock();
    int t = -1, hs_seen = 0, ov;
    pwm_cmd = 1'b1;
    tick(10);
    vboot_above_off = 0; vboot_above_on = 0;
    tick(1);
    check_int("R9", "hs one cycle after boot trip", int'(hs_gate), 0);
    check_int("R9", "ls stays off under boot trip", int'(ls_gate), 0);
    tick(5);
    step_pwm(1'b0, ov, t, ov);
    check_int("R9", "ls follows pwm low under boot lock", t, 4 + 4);
    step_pwm(1'b1, t, ov, ov);
    check_int("R9", "ls falls on pwm high under boot lock", t, 3 + 2);
    check_int("R9", "hs held under boot lock", int'(hs_gate), 0);
    check_int("R6", "no overlap under boot lock", ov, 0);
    t = -1;
    vboot_above_on = 1; vboot_above_off = 1;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); @(negedge clk);
      if (t < 0 && hs_gate) t = n;
      if (ls_gate) hs_seen++;
    end
    check_int("R11", "hs rise after boot clear", t, 2 + 4);
    check_int("R11", "ls off after boot clear", hs_seen, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_and_start();
    t_switch(2, 4, 0, "p2d4");
    t_switch(0, 1, 2, "p0d1lag2");
    t_switch(1, 0, 0, "p1d0");
    t_switch(1, 1, 0, "p1d1");
    t_stuck_feedback();
    t_abort();
    t_main_lock();
    t_boot_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule